// File: doc/BRIEF.md
# Byte-Interleaving Four-Channel Serializer

This block merges four byte-wide input channels into a single byte-wide output stream that runs at four times the input word rate. Everything is clocked by one fast clock. An internal slot counter divides that clock by four and produces a one-cycle load strobe that defines the slow input rate. Upstream logic presents a new word on every channel once per slow period. The block captures all four bytes on the strobe edge.

On the next strobe, the captured word moves into eight four-bit shift registers, one for each bit position of the byte. Together these present one complete byte per fast cycle, in channel order 0, 1, 2, 3. One group follows the next with no idle cycle. A start-of-group flag is high while the channel-0 byte is on the output. A valid flag rises when the first captured group reaches the output and stays high from then on.

Top module: `byte_serializer`

## Requirements
- R1: Channel c occupies bits `ch_in[c*8+7 : c*8]`. The output presents one whole byte per fast cycle, and a group appears in the order channel 0, 1, 2, 3.
- R2: `load_stb` is high for exactly one cycle in every four. After reset is released, it is first high in the fourth cycle, that is, after three rising edges.
- R3: Inputs are sampled on the rising edge that ends a cycle in which `load_stb` is high. Call that edge E. The channel-0 byte of the sampled group is on `ser_data` after edge E+4, and the channel-c byte is on `ser_data` after edge E+4+c.
- R4: Consecutive groups follow each other with no idle cycle. The channel-0 byte of a group comes in the cycle right after the channel-3 byte of the previous group.
- R5: `sof` is high exactly in the cycles in which a channel-0 byte is on `ser_data`, and low in every other cycle.
- R6: `ser_valid` is low from reset until the first captured group reaches the output, which happens after the 8th rising edge following reset release. From then on it stays high.
- R7: While `rst` is high, and in the first cycle after it is released, `ser_data` is 0 and `sof`, `ser_valid` and `load_stb` are low. `ser_data` stays 0 until the first group reaches the output.
- R8: Input values present on any edge other than a sampling edge do not affect `ser_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_in | input | NUM_CH*DATA_W | Packed input bytes, channel c at bits c*DATA_W upward |
| load_stb | output | 1 | Slow-rate strobe: inputs are sampled at the end of this cycle |
| ser_data | output | DATA_W | Serialized byte stream |
| sof | output | 1 | High while the channel-0 byte is on ser_data |
| ser_valid | output | 1 | High once the stream carries real groups |

## Verification
On every strobe edge two things happen at once. The capture register takes the new input word, and the same edge moves its previous contents into the lane shift registers. A fault in ordering would therefore leak bytes of the new group into the old group, or repeat an old byte. The bench provokes this by presenting a different word in every slow period. It drives unrelated junk values in the three cycles between sampling edges. It judges every output cycle against a byte computed from the group index and channel slot, with the fixed latency of R3, so that any mixing of groups or any leak of the junk values shows up.

// File: rtl/byte_serializer_pkg.sv
package byte_serializer_pkg;
  localparam int DEF_CH = 4;
  localparam int DEF_W  = 8;

  typedef struct packed {
    logic first;
    logic valid;
  } frame_flags_t;
endpackage

// File: rtl/slot_timer.sv
module slot_timer #(
  parameter int NUM_CH = 4
) (
  input  logic clk,
  input  logic rst,
  output logic stb
);
  localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [CW-1:0] LAST = CW'(NUM_CH - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign stb = (cnt_q == LAST);

  assert_stb_gap_R2: assert property (@(posedge clk) disable iff (rst)
    stb |=> !stb);
  assert_stb_period_R2: assert property (@(posedge clk) disable iff (rst)
    stb |-> ##4 stb);
endmodule

// File: rtl/capture_reg.sv
module capture_reg #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     stb,
  input  logic [NUM_CH*DATA_W-1:0] din,
  output logic [NUM_CH*DATA_W-1:0] word_q
);
  always_ff @(posedge clk) begin
    if (rst)      word_q <= '0;
    else if (stb) word_q <= din;
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(stb) |-> $stable(word_q));
endmodule

// File: rtl/lane_shift.sv
module lane_shift #(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DEPTH-1:0] par_in,
  output logic             bit_out
);
  logic [DEPTH-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst)       sr_q <= '0;
    else if (load) sr_q <= par_in;
    else           sr_q <= {1'b0, sr_q[DEPTH-1:1]};
  end

  assign bit_out = sr_q[0];

  assert_slot0_R1: assert property (@(posedge clk) disable iff (rst)
    load |=> (bit_out == $past(par_in[0])));
endmodule

// File: rtl/frame_flags.sv
module frame_flags
  import byte_serializer_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         stb,
  output frame_flags_t flags_q
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      flags_q <= '0;
    end else begin
      if (stb) armed_q <= 1'b1;
      flags_q.first <= stb && armed_q;
      if (stb && armed_q) flags_q.valid <= 1'b1;
    end
  end

  assert_valid_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    flags_q.valid |=> flags_q.valid);
  assert_sof_single_R5: assert property (@(posedge clk) disable iff (rst)
    flags_q.first |=> !flags_q.first);
  assert_sof_valid_R5: assert property (@(posedge clk) disable iff (rst)
    flags_q.first |-> flags_q.valid);
endmodule

// File: rtl/byte_serializer.sv
module byte_serializer
  import byte_serializer_pkg::*;
#(
  parameter int NUM_CH = DEF_CH,
  parameter int DATA_W = DEF_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH*DATA_W-1:0] ch_in,
  output logic                     load_stb,
  output logic [DATA_W-1:0]        ser_data,
  output logic                     sof,
  output logic                     ser_valid
);
  localparam int WORD_W = NUM_CH * DATA_W;

  logic [WORD_W-1:0] word_q;
  frame_flags_t      flags;
  logic              stb;

  slot_timer #(.NUM_CH(NUM_CH)) u_timer (
    .clk(clk), .rst(rst), .stb(stb)
  );

  capture_reg #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .stb(stb), .din(ch_in), .word_q(word_q)
  );

  for (genvar b = 0; b < DATA_W; b++) begin : g_lane
    logic [NUM_CH-1:0] lane_bits;
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign lane_bits[c] = word_q[c*DATA_W + b];
    end
    lane_shift #(.DEPTH(NUM_CH)) u_lane (
      .clk(clk), .rst(rst), .load(stb),
      .par_in(lane_bits), .bit_out(ser_data[b])
    );
  end

  frame_flags u_flags (
    .clk(clk), .rst(rst), .stb(stb), .flags_q(flags)
  );

  assign load_stb  = stb;
  assign sof       = flags.first;
  assign ser_valid = flags.valid;

  assert_sof_after_stb_R5: assert property (@(posedge clk) disable iff (rst)
    sof |-> $past(load_stb));
  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !ser_valid |-> (ser_data == '0));
endmodule

// File: tb/byte_serializer_tb.sv
module byte_serializer_tb;
  localparam int NUM_CH = 4;
  localparam int DATA_W = 8;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic [NUM_CH*DATA_W-1:0] ch_in = '0;
  logic                     load_stb;
  logic [DATA_W-1:0]        ser_data;
  logic                     sof;
  logic                     ser_valid;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  byte_serializer #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .ch_in(ch_in), .load_stb(load_stb),
    .ser_data(ser_data), .sof(sof), .ser_valid(ser_valid)
  );

  function automatic logic [7:0] gbyte(int seed, int n, int c);
    int v;
    case (n % 8)
      0: v = 0;
      1: v = 255;
      2: v = 1 << ((n / 8 + c) % 8);
      3: v = 255 ^ (1 << ((n / 8 + c) % 8));
      default: v = (n * 73 + c * 29 + seed * 11) ^ (n >> 3) ^ (c << 5);
    endcase
    return v[7:0];
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run(int seed, int cycles);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 reset data", int'(ser_data), 0);
    check("R7 reset sof", int'(sof), 0);
    check("R7 reset valid", int'(ser_valid), 0);
    check("R7 reset strobe", int'(load_stb), 0);
    rst = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      int slot;
      int grp;
      slot = k % NUM_CH;
      check("R2 strobe", int'(load_stb), (slot == NUM_CH - 1) ? 1 : 0);
      check("R6 valid", int'(ser_valid), (k >= 2 * NUM_CH) ? 1 : 0);
      if (k >= 2 * NUM_CH) begin
        grp = k / NUM_CH - 2;
        check("R1/R3/R4/R8 data", int'(ser_data), int'(gbyte(seed, grp, slot)));
        check("R5 sof", int'(sof), (slot == 0) ? 1 : 0);
      end else begin
        check("R7 data before first group", int'(ser_data), 0);
        check("R5 sof before first group", int'(sof), 0);
      end
      if (slot == NUM_CH - 1) begin
        for (int c = 0; c < NUM_CH; c++)
          ch_in[c*DATA_W +: DATA_W] = gbyte(seed, k / NUM_CH, c);
      end else begin
        for (int c = 0; c < NUM_CH; c++)
          ch_in[c*DATA_W +: DATA_W] = 8'(~(k * 13 + c * 7 + seed));
      end
      @(negedge clk);
    end
  endtask

  initial begin
    run(1, 1200);
    run(5, 801);
    run(9, 402);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule